// File: doc/BRIEF.md
# In-Order Retirement Buffer with Memory Head Release

This block keeps every dispatched instruction in program order inside a circular buffer of 40 slots. It retires at most one slot per cycle, from the oldest end. Each slot stores the operation kind, the architectural destination, the newly assigned physical register, the physical register it replaces, a destination-present flag and a done bit. The dispatch stage writes the youngest slot and receives the slot number as the instruction's tag. Up to three writeback ports mark tags done in the same cycle. The retire outputs give the rename logic what it needs to update its committed map and to free the old physical register.

Loads and stores are handled differently. The load/store unit holds such an operation in its second stage until the operation owns the oldest slot. The buffer then raises a head-is-memory signal. Once the unit reports that it is ready, the buffer releases the operation for a one-cycle cache access and marks the slot done itself. Writeback marks aimed at memory slots are disregarded. Dispatch also serialises control flow: a branch, jump or branch-and-link is refused while an earlier one has not yet issued. Two counters tally retired loads and retired stores.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `cmt_valid` and `head_mem` are low, `disp_ready` is high for every kind, `mem_release` is low and both retire counters read zero.
- R2: An accepted dispatch takes the slot shown on `disp_tag`. Tags increase by one per accepted dispatch and wrap from 39 to 0.
- R3: `cmt_valid` is high exactly when the buffer is non-empty and its oldest slot is done. In that case the `cmt_*` outputs show that slot's kind, architectural destination, new physical register, previous physical register and destination flag. At most one slot retires per cycle, in dispatch order.
- R4: Up to three writeback marks (`cmp_valid[k]` with tag `cmp_tag[k*6 +: 6]`) can set done bits in the same cycle. A marked slot is retirable from the next cycle.
- R5: With 40 slots occupied, `disp_ready` is low and no dispatch is accepted.
- R6: Kinds 2 (branch), 3 (jump) and 4 (branch-and-link) are control flow. After one of them is accepted, `disp_ready` stays low for control-flow kinds until a cycle with `cf_issued` high has passed. Other kinds are not held back by this rule.
- R7: `head_mem` is high exactly when the oldest slot holds kind 5 (load) or kind 6 (store), is not done, and no cache access for it is in progress.
- R8: `mem_release` equals `head_mem & mem_ready`. The slot becomes done at the end of the following cycle, so it retires two cycles after the release.
- R9: Writeback marks aimed at a load or store slot are ignored. Such a slot becomes done only through R8.
- R10: `ld_count` increments on each retired load and `st_count` on each retired store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 3 | Operation kind (0 ALU, 1 MUL, 2 branch, 3 jump, 4 branch-and-link, 5 load, 6 store) |
| disp_has_dst | input | 1 | Instruction writes a register |
| disp_arch | input | 4 | Architectural destination |
| disp_phys | input | 5 | Newly assigned physical register |
| disp_prev | input | 5 | Physical register previously mapped |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 6 | Slot assigned to the dispatch |
| cf_issued | input | 1 | Pending control-flow instruction issued |
| cmp_valid | input | 3 | Writeback mark valid per port |
| cmp_tag | input | 18 | Three packed 6-bit tags |
| mem_ready | input | 1 | Load/store unit has the oldest memory op ready |
| head_mem | output | 1 | Oldest slot is a memory op awaiting access |
| mem_release | output | 1 | Cache access starts this cycle |
| cmt_valid | output | 1 | Oldest slot retires this cycle |
| cmt_kind | output | 3 | Kind of the retiring slot |
| cmt_has_dst | output | 1 | Retiring slot writes a register |
| cmt_arch | output | 4 | Architectural destination retiring |
| cmt_phys | output | 5 | Physical register becoming committed |
| cmt_prev | output | 5 | Physical register to free |
| ld_count | output | 16 | Retired loads |
| st_count | output | 16 | Retired stores |

## Verification
A directed fill of 40 plain ALU dispatches with no marks shows the full stall. A single cycle with three marks on the oldest tags then shows that one burst frees three slots but they retire one per cycle. Further dispatch after the drain crosses the wrap from tag 39 to 0. A long random phase mixes all seven kinds with scattered marks (some aimed at memory slots), random `mem_ready` and random `cf_issued`. It separates a design that retires out of order, lets marks finish memory slots, mistimes the release-to-done delay or stalls the wrong kinds from one that follows the rules.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ARCH_W = 4;
  localparam int PHYS_W = 5;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_ALU = 3'd0,
    K_MUL = 3'd1,
    K_BRZ = 3'd2,
    K_JMP = 3'd3,
    K_BAL = 3'd4,
    K_LD  = 3'd5,
    K_ST  = 3'd6
  } op_kind_e;

  function automatic logic kind_is_ctl(input logic [KIND_W-1:0] k);
    return (k == K_BRZ) || (k == K_JMP) || (k == K_BAL);
  endfunction

  function automatic logic kind_is_mem(input logic [KIND_W-1:0] k);
    return (k == K_LD) || (k == K_ST);
  endfunction
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int DEPTH = 40,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] ptr_d, ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R2
endmodule

// File: rtl/rob_cf_gate.sv
module rob_cf_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_accept,
  input  logic cf_issued,
  output logic ctl_pend
);
  logic pend_d, pend_q;

  always_comb begin
    pend_d = pend_q;
    if (cf_issued)  pend_d = 1'b0;
    if (ctl_accept) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign ctl_pend = pend_q;

  AST_CF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cf_issued) |=> pend_q); // R6
  AST_CF_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !ctl_accept); // R6
endmodule

// File: rtl/rob_mem_gate.sv
module rob_mem_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic head_open,
  input  logic mem_ready,
  output logic head_mem,
  output logic mem_release,
  output logic mem_finish
);
  logic busy_d, busy_q;

  assign head_mem    = head_open && !busy_q;
  assign mem_release = head_mem && mem_ready;
  assign mem_finish  = busy_q;

  always_comb begin
    busy_d = busy_q;
    if (busy_q)      busy_d = 1'b0;
    if (mem_release) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  AST_MEM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_release |=> (mem_finish && !head_mem)); // R8
  AST_MEM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_finish |=> !mem_finish); // R8
endmodule

// File: rtl/rob_retire_count.sv
module rob_retire_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_ld,
  input  logic          pop_st,
  output logic [CW-1:0] ld_count,
  output logic [CW-1:0] st_count
);
  logic [CW-1:0] ld_d, ld_q, st_d, st_q;

  always_comb begin
    ld_d = ld_q;
    st_d = st_q;
    if (pop_ld) ld_d = ld_q + 1'b1;
    if (pop_st) st_d = st_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q <= '0;
      st_q <= '0;
    end else begin
      ld_q <= ld_d;
      st_q <= st_d;
    end
  end

  assign ld_count = ld_q;
  assign st_count = st_q;

  AST_CNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_ld && pop_st)); // R10
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 40,
  parameter int NCMP  = 3,
  parameter int CW    = 16,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  input  logic [2:0]                disp_kind,
  input  logic                      disp_has_dst,
  input  logic [3:0]                disp_arch,
  input  logic [4:0]                disp_phys,
  input  logic [4:0]                disp_prev,
  output logic                      disp_ready,
  output logic [IW-1:0]             disp_tag,
  input  logic                      cf_issued,
  input  logic [NCMP-1:0]           cmp_valid,
  input  logic [NCMP*IW-1:0]        cmp_tag,
  input  logic                      mem_ready,
  output logic                      head_mem,
  output logic                      mem_release,
  output logic                      cmt_valid,
  output logic [2:0]                cmt_kind,
  output logic                      cmt_has_dst,
  output logic [3:0]                cmt_arch,
  output logic [4:0]                cmt_phys,
  output logic [4:0]                cmt_prev,
  output logic [CW-1:0]             ld_count,
  output logic [CW-1:0]             st_count
);
  import rob_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [KIND_W-1:0] kind_q  [DEPTH];
  logic              hdst_q  [DEPTH];
  logic [ARCH_W-1:0] arch_q  [DEPTH];
  logic [PHYS_W-1:0] phys_q  [DEPTH];
  logic [PHYS_W-1:0] prev_q  [DEPTH];
  logic [DEPTH-1:0]  done_d, done_q;

  logic [IW-1:0]    head, tail;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             full, empty, push, pop;
  logic             ctl_pend, head_open, mem_finish;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  assign disp_ready = !full && !(kind_is_ctl(disp_kind) && ctl_pend);
  assign disp_tag   = tail;
  assign push       = disp_valid && disp_ready;

  assign cmt_valid   = !empty && done_q[head];
  assign pop         = cmt_valid;
  assign cmt_kind    = kind_q[head];
  assign cmt_has_dst = hdst_q[head];
  assign cmt_arch    = arch_q[head];
  assign cmt_phys    = phys_q[head];
  assign cmt_prev    = prev_q[head];

  assign head_open = !empty && kind_is_mem(kind_q[head]) && !done_q[head];

  rob_ptr #(.DEPTH(DEPTH), .IW(IW)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(pop), .ptr(head));

  rob_ptr #(.DEPTH(DEPTH), .IW(IW)) u_tail (
    .clk(clk), .rst_n(rst_n), .adv(push), .ptr(tail));

  rob_cf_gate u_cf (
    .clk(clk), .rst_n(rst_n),
    .ctl_accept(push && kind_is_ctl(disp_kind)),
    .cf_issued(cf_issued), .ctl_pend(ctl_pend));

  rob_mem_gate u_mem (
    .clk(clk), .rst_n(rst_n), .head_open(head_open), .mem_ready(mem_ready),
    .head_mem(head_mem), .mem_release(mem_release), .mem_finish(mem_finish));

  rob_retire_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .pop_ld(pop && (cmt_kind == K_LD)),
    .pop_st(pop && (cmt_kind == K_ST)),
    .ld_count(ld_count), .st_count(st_count));

  always_comb begin
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NCMP; k++) begin
        if (cmp_valid[k] && (cmp_tag[k*IW +: IW] == IW'(i))) hit = 1'b1;
      end
      done_d[i] = done_q[i];
      if (hit && !kind_is_mem(kind_q[i]))     done_d[i] = 1'b1;
      if (mem_finish && (head == IW'(i)))     done_d[i] = 1'b1;
      if (push && (tail == IW'(i)))           done_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q[i] <= 1'b0;
      else        done_q[i] <= done_d[i];
    end

    always_ff @(posedge clk) begin
      if (push && (tail == IW'(i))) begin
        kind_q[i] <= disp_kind;
        hdst_q[i] <= disp_has_dst;
        arch_q[i] <= disp_arch;
        phys_q[i] <= disp_phys;
        prev_q[i] <= disp_prev;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R5
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R5
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_MEM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    head_mem |-> !cmt_valid); // R9
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int DEPTH = 40;
  localparam int IW    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [2:0]  disp_kind = '0;
  logic        disp_has_dst = 1'b0;
  logic [3:0]  disp_arch = '0;
  logic [4:0]  disp_phys = '0;
  logic [4:0]  disp_prev = '0;
  logic        disp_ready;
  logic [5:0]  disp_tag;
  logic        cf_issued = 1'b0;
  logic [2:0]  cmp_valid = '0;
  logic [17:0] cmp_tag = '0;
  logic        mem_ready = 1'b0;
  logic        head_mem, mem_release, cmt_valid, cmt_has_dst;
  logic [2:0]  cmt_kind;
  logic [3:0]  cmt_arch;
  logic [4:0]  cmt_phys, cmt_prev;
  logic [15:0] ld_count, st_count;

  int checks = 0;
  int errors = 0;

  int       m_count, m_head, m_tail;
  bit       m_pend, m_infl;
  int       m_ld, m_st;
  bit [2:0] m_kind [DEPTH];
  bit       m_hdst [DEPTH];
  bit [3:0] m_arch [DEPTH];
  bit [4:0] m_phys [DEPTH];
  bit [4:0] m_prev [DEPTH];
  bit       m_done [DEPTH];

  always #10 clk = ~clk;

  rob_core u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
    .disp_has_dst(disp_has_dst), .disp_arch(disp_arch), .disp_phys(disp_phys),
    .disp_prev(disp_prev), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cf_issued(cf_issued), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .mem_ready(mem_ready), .head_mem(head_mem), .mem_release(mem_release),
    .cmt_valid(cmt_valid), .cmt_kind(cmt_kind), .cmt_has_dst(cmt_has_dst),
    .cmt_arch(cmt_arch), .cmt_phys(cmt_phys), .cmt_prev(cmt_prev),
    .ld_count(ld_count), .st_count(st_count));

  function automatic bit f_ctl(input bit [2:0] k);
    return (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
  endfunction

  function automatic bit f_mem(input bit [2:0] k);
    return (k == 3'd5) || (k == 3'd6);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit e_full, e_ready, e_hmem, e_cmt, e_rel, push;
    #1;
    e_full  = (m_count == DEPTH);
    e_ready = !e_full && !(f_ctl(disp_kind) && m_pend);
    e_hmem  = (m_count != 0) && f_mem(m_kind[m_head]) && !m_done[m_head] && !m_infl;
    e_cmt   = (m_count != 0) && m_done[m_head];
    e_rel   = e_hmem && mem_ready;
    if (e_full) chk(disp_ready == e_ready, "R5 disp_ready", int'(disp_ready), int'(e_ready));
    else        chk(disp_ready == e_ready, "R6 disp_ready", int'(disp_ready), int'(e_ready));
    chk(int'(disp_tag) == m_tail, "R2 disp_tag", int'(disp_tag), m_tail);
    chk(cmt_valid == e_cmt, "R3 R4 R9 cmt_valid", int'(cmt_valid), int'(e_cmt));
    if (e_cmt) begin
      chk(cmt_kind == m_kind[m_head], "R3 cmt_kind", int'(cmt_kind), int'(m_kind[m_head]));
      chk(cmt_phys == m_phys[m_head], "R3 cmt_phys", int'(cmt_phys), int'(m_phys[m_head]));
      chk(cmt_prev == m_prev[m_head], "R3 cmt_prev", int'(cmt_prev), int'(m_prev[m_head]));
      chk(cmt_arch == m_arch[m_head], "R3 cmt_arch", int'(cmt_arch), int'(m_arch[m_head]));
      chk(cmt_has_dst == m_hdst[m_head], "R3 cmt_has_dst", int'(cmt_has_dst), int'(m_hdst[m_head]));
    end
    chk(head_mem == e_hmem, "R7 head_mem", int'(head_mem), int'(e_hmem));
    chk(mem_release == e_rel, "R8 mem_release", int'(mem_release), int'(e_rel));
    chk(int'(ld_count) == m_ld, "R10 ld_count", int'(ld_count), m_ld);
    chk(int'(st_count) == m_st, "R10 st_count", int'(st_count), m_st);

    push = disp_valid && e_ready;
    if (m_infl) begin
      m_done[m_head] = 1'b1;
      m_infl = 1'b0;
    end
    if (e_rel) m_infl = 1'b1;
    for (int k = 0; k < 3; k++) begin
      int t;
      t = int'(cmp_tag[k*IW +: IW]);
      if (cmp_valid[k] && t < DEPTH && !f_mem(m_kind[t])) m_done[t] = 1'b1;
    end
    if (m_pend && cf_issued) m_pend = 1'b0;
    if (push && f_ctl(disp_kind)) m_pend = 1'b1;
    if (e_cmt) begin
      if (m_kind[m_head] == 3'd5) m_ld++;
      if (m_kind[m_head] == 3'd6) m_st++;
      m_head = (m_head + 1) % DEPTH;
      m_count--;
    end
    if (push) begin
      m_kind[m_tail] = disp_kind;
      m_hdst[m_tail] = disp_has_dst;
      m_arch[m_tail] = disp_arch;
      m_phys[m_tail] = disp_phys;
      m_prev[m_tail] = disp_prev;
      m_done[m_tail] = 1'b0;
      m_tail = (m_tail + 1) % DEPTH;
      m_count++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    disp_valid = 1'b0;
    cmp_valid  = '0;
    cf_issued  = 1'b0;
    mem_ready  = 1'b0;
  endtask

  task automatic rand_payload(input bit [2:0] k);
    disp_kind    = k;
    disp_has_dst = !(k == 3'd2 || k == 3'd3 || k == 3'd6);
    disp_arch    = 4'($urandom_range(0, 15));
    disp_phys    = 5'($urandom_range(0, 31));
    disp_prev    = 5'($urandom_range(0, 31));
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_count = 0; m_head = 0; m_tail = 0; m_pend = 0; m_infl = 0; m_ld = 0; m_st = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_kind[i] = '0; m_hdst[i] = 0; m_arch[i] = '0;
      m_phys[i] = '0; m_prev[i] = '0; m_done[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, probed for a control-flow kind as well
    disp_kind = 3'd2;
    #1;
    chk(disp_ready == 1'b1, "R1 disp_ready", int'(disp_ready), 1);
    chk(cmt_valid == 1'b0, "R1 cmt_valid", int'(cmt_valid), 0);
    chk(head_mem == 1'b0, "R1 head_mem", int'(head_mem), 0);
    chk(mem_release == 1'b0, "R1 mem_release", int'(mem_release), 0);
    chk(ld_count == 16'd0 && st_count == 16'd0, "R1 counters", int'(ld_count + st_count), 0);
    step();

    // R5 and R2: fill with plain ALU ops and no marks
    for (int i = 0; i < DEPTH + 2; i++) begin
      idle_inputs();
      disp_valid = 1'b1;
      rand_payload(3'd0);
      step();
    end
    chk(disp_ready == 1'b0, "R5 full stall", int'(disp_ready), 0);

    // R4: three marks in one cycle on the three oldest tags
    idle_inputs();
    cmp_valid = 3'b111;
    cmp_tag   = {6'd2, 6'd1, 6'd0};
    step();
    idle_inputs();
    for (int i = 0; i < 4; i++) step();

    // drain the rest so tags wrap (R2)
    for (int t = 3; t < DEPTH; t++) begin
      idle_inputs();
      cmp_valid = 3'b001;
      cmp_tag   = {12'd0, 6'(t)};
      step();
    end
    idle_inputs();
    repeat (3) step();

    // R9: a load marked by writeback must stay unretired until released
    idle_inputs();
    disp_valid = 1'b1;
    rand_payload(3'd5);
    step();
    idle_inputs();
    cmp_valid = 3'b001;
    cmp_tag   = {12'd0, 6'(m_head)};
    step();
    idle_inputs();
    step();
    mem_ready = 1'b1;
    step();
    idle_inputs();
    repeat (3) step();

    // random mix over all kinds (R3 R6 R7 R8 R10)
    for (int n = 0; n < 6000; n++) begin
      idle_inputs();
      disp_valid = ($urandom_range(0, 99) < 60);
      rand_payload(3'($urandom_range(0, 6)));
      cf_issued = ($urandom_range(0, 99) < 30);
      mem_ready = ($urandom_range(0, 99) < 50);
      for (int k = 0; k < 3; k++) begin
        if (m_count > 0 && $urandom_range(0, 99) < 45) begin
          cmp_valid[k] = 1'b1;
          cmp_tag[k*IW +: IW] = 6'((m_head + int'($urandom_range(0, m_count - 1))) % DEPTH);
        end
      end
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule